// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

This peripheral holds four down-counters behind a single-cycle 32-bit register bus. Each channel decrements on a tick from its own prescaler. The divider is 1, 16 or 256. A channel counts either the full 32 bits or only the low 16 bits. When a channel passes zero, three bits in its control register decide what happens next:

- it wraps to all ones (free-running),
- it restarts from its reload value (periodic), or
- it stops at zero (one-shot).

All four channels share one set of interrupt registers: a mask, a raw status, a masked status and a write-one-to-clear register. They also share one combined interrupt line. Software that wants an increasing timebase inverts the value it reads. A steady tick comes from writing the same value to the load and background registers. A new period written to the background register only takes effect when the current period ends.

Each channel runs a small state machine with three states:

- **STOP**: the enable bit is clear. The count is frozen and the prescaler phase is held at zero.
- **RUN**: the channel is counting.
- **HALT**: a one-shot has expired and the count is held at zero.

The transitions are:

- *start*: STOP to RUN, when enable becomes set.
- *expire*: RUN to HALT, on an underflow with one-shot set, unless the load register is written in the same cycle.
- *rearm*: HALT to RUN, on a load write while enabled.
- *disable*: RUN or HALT to STOP, when enable is cleared.

Top module: `qtu_top`

## Requirements
- R1: After reset every control, load, count, mask and raw status bit is zero, and the interrupt output is low.
- R2: The address map is word-aligned; any access with address bits 1:0 non-zero is unmapped. The shared registers are:
  - 0x00: mask (read/write).
  - 0x04: raw status (read-only; writes are ignored).
  - 0x08: masked status.
  - 0x0C: clear (write-only; reads as 0).

  Channel n has its group at 0x10 + 0x10*n:
  - +0x0: load.
  - +0x4: current count.
  - +0x8: control.
  - +0xC: background reload.

  The eight words at 0xFE0 to 0xFFC return identification byte k of a parameter in bits 7:0, where k is address bits 4:2. Every other offset reads zero.
- R3: The control byte has these fields:
  - bit 7: enable.
  - bit 6: periodic.
  - bits 3:2: prescaler select (00 divides by 1, 01 by 16, 10 or 11 by 256).
  - bit 1: 32-bit width.
  - bit 0: one-shot.

  Bits 5:4 read back as zero.
- R4: A load write sets the count at once, masked to the current width, and also sets the reload value. A background write changes only the reload value and leaves the count alone. Both the load and background offsets read back the reload value.
- R5: Each tick decrements the count. A tick that finds the count at zero is an underflow. With periodic and one-shot both clear, the count then wraps to 0xFFFF in 16-bit mode or to 0xFFFFFFFF in 32-bit mode. In 16-bit mode only the low 16 bits take part.
- R6: One-shot takes priority over periodic. After an underflow the count stays at zero and no further underflow occurs until a load write restarts the channel.
- R7: With periodic set and one-shot clear, an underflow restarts the count from the reload value, so a load of N gives a period of N+1 ticks.
- R8: Raw status bit n is set on each underflow of channel n. Masked status is raw AND mask, and the interrupt output is the OR of the masked bits.
- R9: Writing a 1 to clear bit n drops raw bit n. An underflow in the same cycle wins over the clear.
- R10: Timing of enable and disable:
  - With the divider at 1, the first decrement happens on the edge after the enabling write; with the divider at D, it happens D edges after it.
  - Clearing enable freezes the count and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| irq_o | output | 1 | OR of all masked interrupt status bits |

## Verification
The bench builds the block with four channels and 32-bit data, the default sizes. It overrides the identification parameter with its own byte pattern, so the identification reads are checked against values the bench chose.

With a 16-bit narrow width inside a 32-bit register, both the masking of a load and the 0xFFFF wrap can be observed. The 4-bit fine and 8-bit coarse prescaler phases make the divide-by-16 and divide-by-256 boundaries short enough to hit on exact edges. This includes the phase restart after a disable.

// File: rtl/qtu_pkg.sv
`timescale 1ns/1ps
package qtu_pkg;

    typedef enum logic [1:0] {
        CH_STOP = 2'd0,
        CH_RUN  = 2'd1,
        CH_HALT = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic       ena;
        logic       periodic;
        logic [1:0] presc;
        logic       wide;
        logic       oneshot;
    } ch_ctrl_t;

    localparam int CTL_ENA_BIT = 7;

    localparam logic [1:0] PRESC_DIV1  = 2'b00;
    localparam logic [1:0] PRESC_DIV16 = 2'b01;

    function automatic ch_ctrl_t ctrl_from_byte(input logic [7:0] b);
        ch_ctrl_t c;
        c.ena      = b[7];
        c.periodic = b[6];
        c.presc    = b[3:2];
        c.wide     = b[1];
        c.oneshot  = b[0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ch_ctrl_t c);
        return {c.ena, c.periodic, 2'b00, c.presc, c.wide, c.oneshot};
    endfunction

endpackage

// File: rtl/qtu_prescaler.sv
`timescale 1ns/1ps
module qtu_prescaler #(
    parameter int FINE_BITS = 4,
    parameter int PHASE_W   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    import qtu_pkg::*;

    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            PRESC_DIV1:  tick = run;
            PRESC_DIV16: tick = run && (&phase_q[FINE_BITS-1:0]);
            default:     tick = run && (&phase_q);
        endcase
    end

endmodule

// File: rtl/qtu_channel.sv
`timescale 1ns/1ps
module qtu_channel #(
    parameter int DATA_W    = 32,
    parameter int NARROW_W  = 16,
    parameter int FINE_BITS = 4,
    parameter int PHASE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_wr,
    input  logic              bg_wr,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [7:0]        ctrl_o,
    output logic              uflow_o,
    output logic              run_o,
    output logic              halt_o
);
    import qtu_pkg::*;

    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    ch_state_e         state_q, state_d;
    ch_ctrl_t          ctrl_q;
    logic [DATA_W-1:0] count_q, reload_q, wmask;
    logic              tick, at_zero, ena_nx;

    assign wmask   = ctrl_q.wide ? '1 : NARROW_MASK;
    assign at_zero = ((count_q & wmask) == '0);
    assign uflow_o = tick && at_zero;
    assign ena_nx  = ctl_wr ? wdata[CTL_ENA_BIT] : ctrl_q.ena;

    qtu_prescaler #(
        .FINE_BITS(FINE_BITS),
        .PHASE_W  (PHASE_W)
    ) i_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == CH_RUN),
        .sel  (ctrl_q.presc),
        .tick (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start, expire, rearm, disable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: begin
                if (ena_nx) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (!ena_nx)                               state_d = CH_STOP;
                else if (uflow_o && ctrl_q.oneshot && !ld_wr) state_d = CH_HALT;
            end
            CH_HALT: begin
                if (!ena_nx)    state_d = CH_STOP;
                else if (ld_wr) state_d = CH_RUN;
            end
            default: state_d = CH_STOP;
        endcase
    end

    // outputs: control, count and reload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            if (ctl_wr) ctrl_q <= ctrl_from_byte(wdata[7:0]);
            if (ld_wr || bg_wr) reload_q <= wdata;
            if (ld_wr) begin
                count_q <= wdata & wmask;
            end else if (uflow_o) begin
                if (ctrl_q.oneshot)       count_q <= '0;
                else if (ctrl_q.periodic) count_q <= reload_q & wmask;
                else                      count_q <= wmask;
            end else if (tick) begin
                count_q <= (count_q - 1'b1) & wmask;
            end
        end
    end

    assign count_o  = count_q;
    assign reload_o = reload_q;
    assign ctrl_o   = ctrl_to_byte(ctrl_q);
    assign run_o    = (state_q == CH_RUN);
    assign halt_o   = (state_q == CH_HALT);

endmodule

// File: rtl/qtu_irq_bank.sv
`timescale 1ns/1ps
module qtu_irq_bank #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_wr,
    input  logic           clr_wr,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] uflow,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] raw_o,
    output logic           irq_o
);
    logic [NCH-1:0] mask_q, raw_q, clr_bits;

    assign clr_bits = clr_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_wr) mask_q <= wdata;
            raw_q <= (raw_q & ~clr_bits) | uflow;
        end
    end

    assign mask_o = mask_q;
    assign raw_o  = raw_q;
    assign irq_o  = |(raw_q & mask_q);

endmodule

// File: rtl/qtu_top.sv
`timescale 1ns/1ps
module qtu_top #(
    parameter int          NUM_TIMERS = 4,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter int          NARROW_W   = 16,
    parameter int          FINE_BITS  = 4,
    parameter int          PHASE_W    = 8,
    parameter logic [63:0] ID_BYTES   = 64'hB1_05_F0_0D_13_58_20_7A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int GRP_W = 4;

    logic [GRP_W-1:0] grp;
    logic [1:0]       sub;
    logic             aligned, page_low, id_page, shared_sel;
    logic             mask_wr, clr_wr;

    logic [NUM_TIMERS-1:0]             ch_ld_wr, ch_bg_wr, ch_ctl_wr;
    logic [NUM_TIMERS-1:0]             ch_uflow, ch_run, ch_halt;
    logic [NUM_TIMERS-1:0]             mask, raw, clr_bits;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] ch_count, ch_reload;
    logic [NUM_TIMERS-1:0][7:0]        ch_ctrl;

    assign grp        = bus_addr[7:4];
    assign sub        = bus_addr[3:2];
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign page_low   = aligned && (bus_addr[ADDR_W-1:8] == '0);
    assign id_page    = aligned && (&bus_addr[ADDR_W-1:5]);
    assign shared_sel = page_low && (grp == '0);
    assign mask_wr    = bus_we && shared_sel && (sub == 2'd0);
    assign clr_wr     = bus_we && shared_sel && (sub == 2'd3);
    assign clr_bits   = clr_wr ? bus_wdata[NUM_TIMERS-1:0] : '0;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
        logic hit;
        assign hit          = bus_we && page_low && (grp == GRP_W'(i + 1));
        assign ch_ld_wr[i]  = hit && (sub == 2'd0);
        assign ch_ctl_wr[i] = hit && (sub == 2'd2);
        assign ch_bg_wr[i]  = hit && (sub == 2'd3);

        qtu_channel #(
            .DATA_W   (DATA_W),
            .NARROW_W (NARROW_W),
            .FINE_BITS(FINE_BITS),
            .PHASE_W  (PHASE_W)
        ) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_wr   (ch_ld_wr[i]),
            .bg_wr   (ch_bg_wr[i]),
            .ctl_wr  (ch_ctl_wr[i]),
            .wdata   (bus_wdata),
            .count_o (ch_count[i]),
            .reload_o(ch_reload[i]),
            .ctrl_o  (ch_ctrl[i]),
            .uflow_o (ch_uflow[i]),
            .run_o   (ch_run[i]),
            .halt_o  (ch_halt[i])
        );
    end

    qtu_irq_bank #(.NCH(NUM_TIMERS)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_wr(mask_wr),
        .clr_wr (clr_wr),
        .wdata  (bus_wdata[NUM_TIMERS-1:0]),
        .uflow  (ch_uflow),
        .mask_o (mask),
        .raw_o  (raw),
        .irq_o  (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (shared_sel) begin
            unique case (sub)
                2'd0:    bus_rdata = DATA_W'(mask);
                2'd1:    bus_rdata = DATA_W'(raw);
                2'd2:    bus_rdata = DATA_W'(raw & mask);
                default: bus_rdata = '0;
            endcase
        end else if (id_page) begin
            bus_rdata = DATA_W'(ID_BYTES[{bus_addr[4:2], 3'b000} +: 8]);
        end else begin
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (page_low && grp == GRP_W'(i + 1)) begin
                    unique case (sub)
                        2'd1:    bus_rdata = ch_count[i];
                        2'd2:    bus_rdata = DATA_W'(ch_ctrl[i]);
                        default: bus_rdata = ch_reload[i];
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/qtu_checker.sv
`timescale 1ns/1ps
module qtu_checker #(
    parameter int NCH    = 4,
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      irq_o,
    input logic [NCH-1:0]            raw,
    input logic [NCH-1:0]            mask,
    input logic [NCH-1:0]            uflow,
    input logic [NCH-1:0]            halted,
    input logic [NCH-1:0]            running,
    input logic [NCH-1:0]            ld_wr,
    input logic [NCH-1:0]            clr_bits,
    input logic [NCH-1:0][DATA_W-1:0] counts
);
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw != '0 && mask != '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_uflow_sets_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
            uflow[i] |=> raw[i]);

        p_clear_drops_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_bits[i] && !uflow[i]) |=> !raw[i]);

        p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            halted[i] |-> !uflow[i]);

        p_stop_no_uflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !running[i] |-> !uflow[i]);

        p_frozen_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!running[i] && !ld_wr[i]) |=> $stable(counts[i]));
    end
endmodule

bind qtu_top qtu_checker #(
    .NCH   (NUM_TIMERS),
    .DATA_W(DATA_W)
) i_qtu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_o   (irq_o),
    .raw     (raw),
    .mask    (mask),
    .uflow   (ch_uflow),
    .halted  (ch_halt),
    .running (ch_run),
    .ld_wr   (ch_ld_wr),
    .clr_bits(clr_bits),
    .counts  (ch_count)
);

// File: tb/test_qtu_top.sv
`timescale 1ns/1ps
module test_qtu_top;
    localparam logic [63:0] TB_ID = 64'hC3_1E_99_04_62_AB_5D_27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    qtu_top #(.ID_BYTES(TB_ID)) i_qtu_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    localparam logic [11:0] A_MASK = 12'h000, A_RAW = 12'h004,
                            A_MIS = 12'h008, A_CLR = 12'h00C;

    function automatic logic [11:0] ta(input int n, input int off);
        return 12'(16 + 16 * n + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(ta(0, 8), v);  chk("R1 ctrl0", v, 0);
        rd(ta(0, 4), v);  chk("R1 count0", v, 0);
        rd(ta(3, 0), v);  chk("R1 load3", v, 0);
        rd(A_RAW, v);     chk("R1 raw", v, 0);
        rd(A_MASK, v);    chk("R1 mask", v, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_MASK, 32'hF); rd(A_MASK, v); chk("R2 mask rw", v, 32'hF);
        wr(A_MASK, 0);
        wr(A_RAW, 32'hF);  rd(A_RAW, v);  chk("R2 raw read-only", v, 0);
        rd(A_CLR, v);      chk("R2 clear reads zero", v, 0);
        rd(12'h100, v);    chk("R2 unmapped", v, 0);
        rd(12'h012, v);    chk("R2 misaligned", v, 0);
        rd(12'hFE0, v);    chk("R2 id byte0", v, 32'h27);
        rd(12'hFFC, v);    chk("R2 id byte7", v, 32'hC3);
        wr(ta(2, 0), 32'h1234);
        rd(ta(2, 0), v);   chk("R4 load readback", v, 32'h1234);
        rd(ta(2, 4), v);   chk("R4 load sets count", v, 32'h1234);
        wr(ta(2, 8), 32'h7F);
        rd(ta(2, 8), v);   chk("R3 ctrl readback", v, 32'h4F);
        wr(ta(2, 8), 0);
    endtask

    task automatic t_free32();
        logic [31:0] v, v1, v2;
        wr(A_CLR, 32'hF);
        wr(ta(0, 0), 3);
        wr(ta(0, 8), 32'h82);
        rd(ta(0, 4), v);  chk("R10 first decrement", v, 2);
        rd(ta(0, 4), v);  chk("R5 decrement", v, 1);
        repeat (2) @(negedge clk);
        rd(ta(0, 4), v);  chk("R5 wrap 32", v, 32'hFFFF_FFFE);
        rd(A_RAW, v);     chk("R8 raw on underflow", v, 1);
        chk("R8 irq masked off", {31'd0, irq_o}, 0);
        rd(A_MIS, v);     chk("R8 masked status", v, 0);
        wr(A_CLR, 1);
        rd(A_RAW, v);     chk("R9 clear", v, 0);
        wr(ta(0, 8), 0);
        rd(ta(0, 4), v1);
        repeat (5) @(negedge clk);
        rd(ta(0, 4), v2);
        chk("R10 frozen", v2, v1);
    endtask

    task automatic t_free16();
        logic [31:0] v;
        wr(ta(1, 0), 32'h12345);
        rd(ta(1, 4), v);  chk("R5 narrow load mask", v, 32'h2345);
        wr(ta(1, 0), 1);
        wr(ta(1, 8), 32'h80);
        rd(ta(1, 4), v);  chk("R5 narrow count", v, 0);
        rd(ta(1, 4), v);  chk("R5 wrap 16", v, 32'hFFFF);
        wr(ta(1, 8), 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(A_CLR, 32'hF);
        wr(A_MASK, 4);
        wr(ta(2, 0), 2);
        wr(ta(2, 8), 32'hC3);
        repeat (5) @(negedge clk);
        rd(ta(2, 4), v);  chk("R6 halts at zero", v, 0);
        rd(A_RAW, v);     chk("R8 oneshot raw", v & 4, 4);
        chk("R8 irq asserted", {31'd0, irq_o}, 1);
        wr(A_CLR, 4);
        rd(A_RAW, v);     chk("R9 clear bit2", v & 4, 0);
        chk("R9 irq drops", {31'd0, irq_o}, 0);
        repeat (10) @(negedge clk);
        rd(A_RAW, v);     chk("R6 no further underflow", v & 4, 0);
        wr(ta(2, 0), 1);
        repeat (3) @(negedge clk);
        rd(A_RAW, v);     chk("R6 rearm by load", v & 4, 4);
        rd(ta(2, 4), v);  chk("R6 halted again", v, 0);
        wr(ta(2, 8), 0);
        wr(A_CLR, 32'hF);
        wr(A_MASK, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(ta(3, 0), 4);
        wr(ta(3, 8), 32'hC2);
        repeat (4) @(negedge clk);
        rd(ta(3, 4), v);  chk("R7 reload after underflow", v, 4);
        wr(ta(3, 12), 9);
        rd(ta(3, 4), v);  chk("R4 background leaves count", v, 1);
        rd(ta(3, 0), v);  chk("R4 load reads reload", v, 9);
        rd(ta(3, 4), v);  chk("R7 new reload at underflow", v, 9);
        wr(ta(3, 8), 0);
        wr(A_CLR, 32'hF);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(ta(0, 0), 100);
        wr(ta(0, 8), 32'h86);
        repeat (14) @(negedge clk);
        rd(ta(0, 4), v);  chk("R3 div16 hold", v, 100);
        rd(ta(0, 4), v);  chk("R3 div16 tick", v, 99);
        wr(ta(0, 8), 32'h06);
        repeat (7) @(negedge clk);
        wr(ta(0, 8), 32'h86);
        repeat (14) @(negedge clk);
        rd(ta(0, 4), v);  chk("R10 phase restart hold", v, 99);
        rd(ta(0, 4), v);  chk("R10 phase restart tick", v, 98);
        wr(ta(0, 8), 0);
        wr(ta(1, 0), 5);
        wr(ta(1, 8), 32'h8A);
        repeat (254) @(negedge clk);
        rd(ta(1, 4), v);  chk("R3 div256 hold", v, 5);
        rd(ta(1, 4), v);  chk("R3 div256 tick", v, 4);
        wr(ta(1, 8), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_free32();
        t_free16();
        t_oneshot();
        t_periodic();
        t_prescale();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule